// File: doc/BRIEF.md
# Wrapping Bit Range Mask Generator

This block turns a pair of bit indices into a contiguous run of ones. Indices count from the most significant bit, so index 0 is the top bit of the word. The run starts at the begin index and stops at the end index, and both of those bits are included. If the begin index is larger than the end index, the run goes past the least significant bit and continues from the top of the word. The result is a mask that is split into two pieces at the two ends of the word.

A rotate-and-mask datapath uses the mask to choose which bits of a rotated operand it keeps. The block is purely combinational. A narrow mode moves both indices into the lower half of the word, so a half-width operation can use the same indices as a full-width one. The mask is built from two one-sided masks. A begin-side mask has ones from the begin bit down to the LSB. An end-side mask has ones from the MSB down to the end bit. The block ANDs the two masks when the run does not wrap and ORs them when it does.

Top module: `wrap_mask_gen`

## Requirements
- R1: When the effective begin index b is at most the effective end index e, the mask has a one at every MSB-first position p with b <= p <= e and zeros at all other positions. Position p is vector bit W-1-p.
- R2: With W=8: begin 1 and end 7 give 8'b01111111, and begin 3 and end 4 give 8'b00011000.
- R3: When b > e, the mask has a one at every position p with p >= b or p <= e and zeros at all other positions. With W=8, begin 7 and end 1 give 8'b11000001.
- R4: The mask is all ones exactly when b == (e+1) mod W. With W=8, begin 4 and end 3 give 8'hFF.
- R5: When b == e, the mask has exactly one bit set, at position b.
- R6: When narrow_en is 1, each effective index is W/2 plus the low log2(W)-1 bits of its port, so the port's top index bit has no effect. With W=64 this adds 32 to both indices. When narrow_en is 0, the effective index equals the port value.
- R7: The mask always has a one at position b and a one at position e.
- R8: The mask has e-b+1 ones when b <= e, and W-(b-e)+1 ones when b > e.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| begin_idx | input | $clog2(W) | MSB-first index of the first bit of the run |
| end_idx | input | $clog2(W) | MSB-first index of the last bit of the run (inclusive) |
| narrow_en | input | 1 | Moves both indices into the lower half of the word |
| mask_o | output | W | Generated mask |

## Verification
A fault in this block shows up on mask_o in the same evaluation as the input change, because no state sits between the indices and the output. If the inclusive end offset is wrong, the run is one bit too long or too short, and the popcount is off by one. If the wrong combine operator is selected, a wrapping run comes out empty or a plain run fills the whole word. The all-ones boundary and the single-bit case show these faults most clearly. The sweep covers every begin and end pair in both modes, at a width of 8 and at a width of 64.

// File: rtl/wrap_mask_pkg.sv
package wrap_mask_pkg;

    typedef enum logic {
        JOIN_AND = 1'b0,
        JOIN_OR  = 1'b1
    } join_op_e;

endpackage

// File: rtl/wm_index_map.sv
module wm_index_map #(
    parameter int W  = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [IW-1:0] idx_i,
    input  logic          narrow_i,
    output logic [IW-1:0] idx_o
);

    // In narrow mode the top index bit is forced high, which adds W/2 to
    // any value held in the low IW-1 bits.
    always_comb begin
        if (narrow_i) begin
            idx_o = {1'b1, idx_i[IW-2:0]};
        end else begin
            idx_o = idx_i;
        end
    end

endmodule

// File: rtl/wm_edge_mask.sv
module wm_edge_mask #(
    parameter int W        = 64,
    parameter bit FROM_TOP = 1'b0,
    localparam int IW = $clog2(W)
) (
    input  logic [IW-1:0] idx_i,
    output logic [W-1:0]  mask_o
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    generate
        if (FROM_TOP) begin : g_end_side
            // Ones from the MSB down to idx_i inclusive. The shift is one
            // larger than the index because the end bit is inclusive.
            logic [IW:0] shamt;
            always_comb begin
                shamt  = {1'b0, idx_i} + 1'b1;
                mask_o = ~(ALL_ONES >> shamt);
            end
        end else begin : g_begin_side
            // Ones from idx_i down to the LSB.
            always_comb begin
                mask_o = ALL_ONES >> idx_i;
            end
        end
    endgenerate

endmodule

// File: rtl/wm_join.sv
module wm_join
    import wrap_mask_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] begin_side_i,
    input  logic [W-1:0] end_side_i,
    input  join_op_e     op_i,
    output logic [W-1:0] mask_o
);

    always_comb begin
        unique case (op_i)
            JOIN_AND: mask_o = begin_side_i & end_side_i;
            JOIN_OR:  mask_o = begin_side_i | end_side_i;
            default:  mask_o = '0;
        endcase
    end

endmodule

// File: rtl/wrap_mask_gen.sv
module wrap_mask_gen
    import wrap_mask_pkg::*;
#(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [IW-1:0] begin_idx,
    input  logic [IW-1:0] end_idx,
    input  logic          narrow_en,
    output logic [W-1:0]  mask_o
);

    logic [IW-1:0] begin_eff;
    logic [IW-1:0] end_eff;
    logic [W-1:0]  begin_side;
    logic [W-1:0]  end_side;
    join_op_e      join_op;

    wm_index_map #(.W(W)) u_map_begin (
        .idx_i    (begin_idx),
        .narrow_i (narrow_en),
        .idx_o    (begin_eff)
    );

    wm_index_map #(.W(W)) u_map_end (
        .idx_i    (end_idx),
        .narrow_i (narrow_en),
        .idx_o    (end_eff)
    );

    wm_edge_mask #(.W(W), .FROM_TOP(1'b0)) u_begin_side (
        .idx_i  (begin_eff),
        .mask_o (begin_side)
    );

    wm_edge_mask #(.W(W), .FROM_TOP(1'b1)) u_end_side (
        .idx_i  (end_eff),
        .mask_o (end_side)
    );

    // A run that does not wrap is the overlap of the two one-sided masks.
    // A wrapping run is their union.
    always_comb begin
        join_op = (begin_eff <= end_eff) ? JOIN_AND : JOIN_OR;
    end

    wm_join #(.W(W)) u_join (
        .begin_side_i (begin_side),
        .end_side_i   (end_side),
        .op_i         (join_op),
        .mask_o       (mask_o)
    );

endmodule

// File: rtl/wrap_mask_gen_chk.sv
module wrap_mask_gen_chk #(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input logic [IW-1:0] begin_idx,
    input logic [IW-1:0] end_idx,
    input logic          narrow_en,
    input logic [W-1:0]  mask_o
);

    int b_c;
    int e_c;
    int want_ones;

    always_comb begin
        b_c = narrow_en ? (W/2 + int'(begin_idx) % (W/2)) : int'(begin_idx);
        e_c = narrow_en ? (W/2 + int'(end_idx) % (W/2)) : int'(end_idx);
        if (b_c <= e_c) begin
            want_ones = e_c - b_c + 1;
        end else begin
            want_ones = W - (b_c - e_c) + 1;
        end
        if (!$isunknown({begin_idx, end_idx, narrow_en, mask_o})) begin
            assert_popcount_R8: assert ($countones(mask_o) == want_ones)
                else $error("popcount of mask does not match the span length");
            assert_begin_bit_set_R7: assert (mask_o[W-1-b_c] == 1'b1)
                else $error("begin bit missing from mask");
            assert_end_bit_set_R7: assert (mask_o[W-1-e_c] == 1'b1)
                else $error("end bit missing from mask");
            assert_full_word_R4: assert ((&mask_o) == (b_c == (e_c + 1) % W))
                else $error("all-ones condition mismatch");
            assert_single_bit_R5: assert ((b_c != e_c) || $onehot(mask_o))
                else $error("equal indices must give one set bit");
        end
    end

endmodule

bind wrap_mask_gen wrap_mask_gen_chk #(.W(W)) u_chk (
    .begin_idx (begin_idx),
    .end_idx   (end_idx),
    .narrow_en (narrow_en),
    .mask_o    (mask_o)
);

// File: tb/wrap_mask_gen_test.sv
module wrap_mask_gen_test;

    localparam int WB  = 64;
    localparam int IWB = $clog2(WB);
    localparam int WS  = 8;
    localparam int IWS = $clog2(WS);

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [IWB-1:0] b_big;
    logic [IWB-1:0] e_big;
    logic           n_big;
    logic [WB-1:0]  m_big;

    logic [IWS-1:0] b_small;
    logic [IWS-1:0] e_small;
    logic           n_small;
    logic [WS-1:0]  m_small;

    int checks = 0;
    int errors = 0;

    wrap_mask_gen #(.W(WB)) uut (
        .begin_idx (b_big),
        .end_idx   (e_big),
        .narrow_en (n_big),
        .mask_o    (m_big)
    );

    wrap_mask_gen #(.W(WS)) uut8 (
        .begin_idx (b_small),
        .end_idx   (e_small),
        .narrow_en (n_small),
        .mask_o    (m_small)
    );

    // Reference: walk every MSB-first position and test membership.
    function automatic logic [63:0] ref_mask(int w, int b, int e);
        logic [63:0] r;
        r = '0;
        for (int p = 0; p < w; p++) begin
            if ((b <= e) ? (p >= b && p <= e) : (p >= b || p <= e)) begin
                r[w-1-p] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic int eff(int w, int idx, bit narrow);
        return narrow ? (w/2 + idx % (w/2)) : idx;
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive_small(int b, int e, bit n);
        @(posedge clk);
        b_small = IWS'(b);
        e_small = IWS'(e);
        n_small = n;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        b_big = '0; e_big = '0; n_big = 1'b0;
        b_small = '0; e_small = '0; n_small = 1'b0;

        // R2: worked 8-bit values
        drive_small(1, 7, 1'b0);
        check("R2", 64'(m_small), 64'h7F);
        drive_small(3, 4, 1'b0);
        check("R2", 64'(m_small), 64'h18);
        // R3: wrap example
        drive_small(7, 1, 1'b0);
        check("R3", 64'(m_small), 64'hC1);
        // R4: all-ones example
        drive_small(4, 3, 1'b0);
        check("R4", 64'(m_small), 64'hFF);
        // R6: in narrow mode the top index bit of each port has no effect
        drive_small(6, 3, 1'b1);
        check("R6", 64'(m_small), ref_mask(WS, 6, 7));
        drive_small(2, 7, 1'b1);
        check("R6", 64'(m_small), ref_mask(WS, 6, 7));

        // Exhaustive sweep at width 8
        for (int n = 0; n < 2; n++) begin
            for (int b = 0; b < WS; b++) begin
                for (int e = 0; e < WS; e++) begin
                    int be;
                    int ee;
                    drive_small(b, e, n[0]);
                    be = eff(WS, b, n[0]);
                    ee = eff(WS, e, n[0]);
                    check(n[0] ? "R6" : ((be <= ee) ? "R1" : "R3"),
                          64'(m_small), ref_mask(WS, be, ee));
                end
            end
        end

        // Exhaustive sweep at width 64
        for (int n = 0; n < 2; n++) begin
            for (int b = 0; b < WB; b++) begin
                for (int e = 0; e < WB; e++) begin
                    int be;
                    int ee;
                    @(posedge clk);
                    b_big = IWB'(b);
                    e_big = IWB'(e);
                    n_big = n[0];
                    @(negedge clk);
                    be = eff(WB, b, n[0]);
                    ee = eff(WB, e, n[0]);
                    check(n[0] ? "R6" : ((be <= ee) ? "R1" : "R3"),
                          m_big, ref_mask(WB, be, ee));
                    if (be == (ee + 1) % WB) begin
                        check("R4", m_big, {64{1'b1}});
                    end
                    if (be == ee) begin
                        check("R5", 64'($countones(m_big)), 64'd1);
                    end
                    if (b == 0 && e == 63 && n == 0) begin
                        check("R7", {62'd0, m_big[63], m_big[0]}, 64'd3);
                    end
                    if (b == 40 && e == 10 && n == 0) begin
                        check("R8", 64'($countones(m_big)), 64'd35);
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule